// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo serial PCM stream: a bit clock, a word-select (frame) clock and one data line. It turns the stream into a pair of 24-bit two's-complement samples, one for the left channel and one for the right. The whole block runs on the bit clock. The frame clock and the data line are sampled on its rising edge. A static three-bit select picks one of six word layouts: right-justified at 16, 20 or 24 bits, left-justified at 24 bits, and I2S at 16 or 24 bits. The block finds each word by counting bit clocks from the frame-clock transitions. Words shorter than 24 bits are sign-extended. After the right word of a pair is complete, the block presents the pair with a one-cycle strobe.

A separate detector watches the data line. It raises a flag once the data has been zero for a long unbroken run of bit clocks, `ZERO_LEN` (65536 by default). The first one bit drops the flag.

The sequencing sits in a three-state machine:
- `ST_SYNC`: entered at reset; moves to `ST_LEFT_GET` on the first frame-clock transition that opens a left channel.
- `ST_LEFT_GET`: moves to `ST_RIGHT_GET` when a left word is captured; falls back to `ST_SYNC` if a right word is captured instead.
- `ST_RIGHT_GET`: returns to `ST_LEFT_GET` when a right word is captured and the pair is emitted; falls back to `ST_SYNC` on an out-of-order left capture.

Top module: `srx_audio_rx`

## Requirements
- R1: `fmt_sel` is {width_hi, width_lo, i2s}. The codes decode as follows: 000 is 16-bit right-justified, 010 is 20-bit right-justified, 100 is 24-bit right-justified, 110 is 24-bit left-justified, 001 is 16-bit I2S and 011 is 24-bit I2S.
- R2: The codes 101 and 111 behave exactly like 24-bit I2S.
- R3: Words arrive MSB first in two's complement. `left_out` and `right_out` carry the word sign-extended to 24 bits.
- R4: In the right-justified modes, a word is the last N bits sampled before the frame-clock transition that ends its channel. Any earlier bits in that channel are ignored.
- R5: In left-justified mode, the MSB is the bit sampled on the first rising bit-clock edge at which the new frame-clock level is seen.
- R6: In the I2S modes, the MSB is sampled one bit clock later than in left-justified mode.
- R7: In the right- and left-justified modes, frame clock high is the left channel. In the I2S modes, frame clock low is the left channel. Left is sent first.
- R8: `pair_valid` is high for exactly one bit-clock cycle per stereo pair. It rises on the cycle after the right word is captured. No pair is reported until a complete left channel has been seen after reset.
- R9: `zero_flag` rises right after `ZERO_LEN` consecutive zero data samples, and not earlier.
- R10: A data sample of one clears the zero-run count and drops `zero_flag` on the same edge.
- R11: While `rst_n` is low, `pair_valid`, `zero_flag`, `left_out` and `right_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Static format/width select (see R1) |
| lrck | input | 1 | Frame clock, one half-period per channel |
| sdata | input | 1 | Serial data, MSB first |
| left_out | output | 24 | Sign-extended left sample of the last pair |
| right_out | output | 24 | Sign-extended right sample of the last pair |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |
| zero_flag | output | 1 | High while the data line has been zero for the full run |

## Verification
The bench sweeps all eight select codes. Each code runs with both the tightest channel length and a 32-bit channel, and the leading or trailing bit slots are filled with ones. A receiver that took the first N bits in right-justified mode, or that was off by one clock in I2S, would therefore return corrupted values instead of the expected ones. Values at the full-scale positive and negative extremes and at minus one expose missing or wrong sign extension. A frame-clock polarity error shows up as swapped channels. A stream that starts in mid-channel checks that a partial first word never produces a strobe. The zero detector is checked one sample before and exactly at the run length, then again after a single one bit interrupts a long run. A detector that did not restart its count would raise the flag too early.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = $clog2(SAMPLE_W + 2);

    typedef enum logic [1:0] {
        ALIGN_RIGHT = 2'd0,
        ALIGN_LEFT  = 2'd1,
        ALIGN_I2S   = 2'd2
    } align_e;

    typedef struct packed {
        align_e     align;
        logic [4:0] width;
    } fmt_t;

    typedef enum logic [1:0] {
        ST_SYNC      = 2'd0,
        ST_LEFT_GET  = 2'd1,
        ST_RIGHT_GET = 2'd2
    } rx_state_e;

endpackage

// File: rtl/srx_fmt_decode.sv
module srx_fmt_decode
    import srx_pkg::*;
(
    input  logic [2:0] fmt_sel,
    output fmt_t       fmt
);

    always_comb begin
        unique case (fmt_sel)
            3'b000:  fmt = '{align: ALIGN_RIGHT, width: 5'd16};
            3'b010:  fmt = '{align: ALIGN_RIGHT, width: 5'd20};
            3'b100:  fmt = '{align: ALIGN_RIGHT, width: 5'd24};
            3'b110:  fmt = '{align: ALIGN_LEFT,  width: 5'd24};
            3'b001:  fmt = '{align: ALIGN_I2S,   width: 5'd16};
            3'b011:  fmt = '{align: ALIGN_I2S,   width: 5'd24};
            default: fmt = '{align: ALIGN_I2S,   width: 5'd24};
        endcase
    end

    always_comb begin
        AST_WIDTH_LEGAL: assert (fmt.width == 5'd16 || fmt.width == 5'd20 || fmt.width == 5'd24); // R1
        if (fmt_sel[2] && fmt_sel[0]) begin
            AST_RESERVED_I2S24: assert (fmt.align == ALIGN_I2S && fmt.width == 5'd24); // R2
        end
    end

endmodule

// File: rtl/srx_frame_track.sv
module srx_frame_track
    import srx_pkg::*;
(
    input  logic                bclk,
    input  logic                rst_n,
    input  fmt_t                fmt,
    input  logic                lrck,
    input  logic                sdata,
    output logic                edge_new,
    output logic                new_is_left,
    output logic                cap_fire,
    output logic                cap_left,
    output logic [SAMPLE_W-1:0] cap_word
);

    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    logic                lr_q;
    logic                primed_q;
    logic                ch_left_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [SAMPLE_W-1:0] shreg_q;
    logic                is_i2s;
    logic [CNT_W-1:0]    target;

    assign is_i2s      = (fmt.align == ALIGN_I2S);
    assign new_is_left = is_i2s ? ~lrck : lrck;
    assign edge_new    = primed_q && (lrck != lr_q);
    assign target      = CNT_W'(fmt.width) + (is_i2s ? CNT_W'(1) : CNT_W'(0));
    assign cap_left    = ch_left_q;

    always_comb begin
        if (!primed_q) begin
            cap_fire = 1'b0;
        end else if (fmt.align == ALIGN_RIGHT) begin
            cap_fire = edge_new;
        end else begin
            cap_fire = (cnt_q == target);
        end
    end

    always_comb begin
        unique case (fmt.width)
            5'd16:   cap_word = {{(SAMPLE_W-16){shreg_q[15]}}, shreg_q[15:0]};
            5'd20:   cap_word = {{(SAMPLE_W-20){shreg_q[19]}}, shreg_q[19:0]};
            default: cap_word = shreg_q;
        endcase
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            lr_q      <= 1'b0;
            primed_q  <= 1'b0;
            ch_left_q <= 1'b0;
            cnt_q     <= '0;
            shreg_q   <= '0;
        end else begin
            lr_q      <= lrck;
            primed_q  <= 1'b1;
            ch_left_q <= new_is_left;
            shreg_q   <= {shreg_q[SAMPLE_W-2:0], sdata};
            if (edge_new) begin
                cnt_q <= CNT_W'(1);
            end else if (cnt_q != CNT_SAT) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/srx_zero_detect.sv
module srx_zero_detect #(
    parameter int ZERO_LEN = 65536
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic sdata,
    output logic zero_flag
);

    localparam int ZW = $clog2(ZERO_LEN + 1);
    localparam logic [ZW-1:0] RUN_FULL = ZW'(ZERO_LEN);
    localparam logic [ZW-1:0] RUN_LAST = ZW'(ZERO_LEN - 1);

    logic [ZW-1:0] run_q;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= '0;
            zero_flag <= 1'b0;
        end else if (sdata) begin
            run_q     <= '0;
            zero_flag <= 1'b0;
        end else if (run_q != RUN_FULL) begin
            run_q <= run_q + ZW'(1);
            if (run_q == RUN_LAST) begin
                zero_flag <= 1'b1;
            end
        end
    end

    AST_ONE_CLEARS_FLAG: assert property (@(posedge bclk) disable iff (!rst_n)
        sdata |=> !zero_flag); // R10

    AST_FLAG_AFTER_ZERO: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(zero_flag) |-> $past(sdata == 1'b0)); // R9

endmodule

// File: rtl/srx_audio_rx.sv
module srx_audio_rx
    import srx_pkg::*;
#(
    parameter int ZERO_LEN = 65536
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_sel,
    input  logic                lrck,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid,
    output logic                zero_flag
);

    fmt_t                fmt;
    logic                edge_new;
    logic                new_is_left;
    logic                cap_fire;
    logic                cap_left;
    logic [SAMPLE_W-1:0] cap_word;
    logic [SAMPLE_W-1:0] left_hold_q;
    rx_state_e           state_q;
    rx_state_e           state_d;
    logic                take_left;
    logic                emit_pair;

    srx_fmt_decode u_decode (
        .fmt_sel (fmt_sel),
        .fmt     (fmt)
    );

    srx_frame_track u_track (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .fmt         (fmt),
        .lrck        (lrck),
        .sdata       (sdata),
        .edge_new    (edge_new),
        .new_is_left (new_is_left),
        .cap_fire    (cap_fire),
        .cap_left    (cap_left),
        .cap_word    (cap_word)
    );

    srx_zero_detect #(.ZERO_LEN(ZERO_LEN)) u_zero (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .sdata     (sdata),
        .zero_flag (zero_flag)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC: begin
                if (edge_new && new_is_left) begin
                    state_d = ST_LEFT_GET;
                end
            end
            ST_LEFT_GET: begin
                if (cap_fire) begin
                    state_d = cap_left ? ST_RIGHT_GET : ST_SYNC;
                end
            end
            ST_RIGHT_GET: begin
                if (cap_fire) begin
                    state_d = cap_left ? ST_SYNC : ST_LEFT_GET;
                end
            end
            default: state_d = ST_SYNC;
        endcase
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
        end else begin
            state_q <= state_d;
        end
    end

    assign take_left = (state_q == ST_LEFT_GET)  && cap_fire &&  cap_left;
    assign emit_pair = (state_q == ST_RIGHT_GET) && cap_fire && !cap_left;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold_q <= '0;
            left_out    <= '0;
            right_out   <= '0;
            pair_valid  <= 1'b0;
        end else begin
            pair_valid <= emit_pair;
            if (take_left) begin
                left_hold_q <= cap_word;
            end
            if (emit_pair) begin
                left_out  <= left_hold_q;
                right_out <= cap_word;
            end
        end
    end

    AST_SINGLE_STROBE: assert property (@(posedge bclk) disable iff (!rst_n)
        pair_valid |=> !pair_valid); // R8

    AST_STROBE_FROM_RIGHT: assert property (@(posedge bclk) disable iff (!rst_n)
        pair_valid |-> $past(state_q == ST_RIGHT_GET)); // R8

endmodule

// File: tb/tb_srx_audio_rx.sv
module tb_srx_audio_rx;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam int ZLEN       = 65536;
    localparam int FRAMES     = 4;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_sel = 3'b000;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        pair_valid;
    logic        zero_flag;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    string cur_tag = "R4";
    logic [23:0] exp_l[$];
    logic [23:0] exp_r[$];

    always #(CLK_PERIOD/2) bclk = ~bclk;

    srx_audio_rx #(.ZERO_LEN(ZLEN)) dut (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .fmt_sel    (fmt_sel),
        .lrck       (lrck),
        .sdata      (sdata),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid),
        .zero_flag  (zero_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge bclk) begin
        if (rst_n && pair_valid) begin
            pulses++;
            if (exp_l.size() == 0) begin
                chk("R8 unexpected strobe", 32'd1, 32'd0);
            end else begin
                chk($sformatf("%s R3 R7 left word", cur_tag), {8'd0, left_out}, {8'd0, exp_l.pop_front()});
                chk($sformatf("%s R3 R7 right word", cur_tag), {8'd0, right_out}, {8'd0, exp_r.pop_front()});
            end
        end
    end

    function automatic void bdecode(input int code, output int n, output int al);
        case (code)
            0: begin n = 16; al = 0; end
            2: begin n = 20; al = 0; end
            4: begin n = 24; al = 0; end
            6: begin n = 24; al = 1; end
            1: begin n = 16; al = 2; end
            3: begin n = 24; al = 2; end
            default: begin n = 24; al = 2; end
        endcase
    endfunction

    function automatic logic [23:0] sext(input logic [23:0] v, input int n);
        logic signed [23:0] t;
        t = $signed(v << (24 - n));
        return 24'(t >>> (24 - n));
    endfunction

    // called at a negedge; returns at the next negedge after the bit was sampled
    task automatic drive_bit(input logic lr, input logic d);
        lrck  = lr;
        sdata = d;
        @(negedge bclk);
    endtask

    task automatic apply_reset(input logic [2:0] code);
        @(negedge bclk);
        rst_n   = 1'b0;
        lrck    = 1'b0;
        sdata   = 1'b0;
        fmt_sel = code;
        repeat (3) @(negedge bclk);
        chk("R11 pair_valid in reset", {31'd0, pair_valid}, 32'd0);
        chk("R11 zero_flag in reset", {31'd0, zero_flag}, 32'd0);
        chk("R11 outputs in reset", {8'd0, left_out ^ right_out}, 32'd0);
        chk("R11 left_out in reset", {8'd0, left_out}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic send_frame(input int n, input int al, input int half,
                              input logic [23:0] lv, input logic [23:0] rv);
        logic [23:0] v;
        logic lr;
        logic b;
        exp_l.push_back(sext(lv, n));
        exp_r.push_back(sext(rv, n));
        for (int ch = 0; ch < 2; ch++) begin
            v  = (ch == 0) ? lv : rv;
            lr = (ch == 0) ? (al != 2) : (al == 2);
            for (int i = 0; i < half; i++) begin
                if (al == 0) b = (i >= half - n) ? v[n - 1 - (i - (half - n))] : 1'b1;
                else if (al == 1) b = (i < n) ? v[n - 1 - i] : 1'b1;
                else b = (i >= 1 && i <= n) ? v[n - i] : 1'b1;
                drive_bit(lr, b);
            end
        end
    endtask

    task automatic run_config(input int code, input int half_sel);
        int n;
        int al;
        int half;
        logic [31:0] mask;
        logic [31:0] h;
        logic [23:0] lv;
        logic [23:0] rv;
        bdecode(code, n, al);
        half = half_sel ? 32 : (n + ((al == 2) ? 1 : 0));
        mask = (32'd1 << n) - 32'd1;
        cur_tag = (code == 5 || code == 7) ? "R2" : (al == 0) ? "R4 R1" : (al == 1) ? "R5 R1" : "R6 R1";
        apply_reset(3'(code));
        pulses = 0;
        // partial channel lead-in with right-channel level: must be ignored (R8)
        for (int i = 0; i < 3; i++) drive_bit((al == 2), 1'b1);
        for (int f = 0; f < FRAMES; f++) begin
            h = (32'(code) * 32'd7919 + 32'(f) * 32'd40503 + 32'(half) * 32'd613) * 32'd2654435761;
            case (f)
                0: begin lv = 24'(mask >> 1); rv = 24'((mask >> 1) + 32'd1); end
                1: begin lv = 24'(mask);      rv = 24'd1; end
                default: begin lv = 24'(h & mask); rv = 24'((h >> 7) & mask); end
            endcase
            send_frame(n, al, half, lv, rv);
        end
        for (int i = 0; i < 4; i++) drive_bit((al != 2), 1'b0);
        chk($sformatf("R8 pair count code %0d half %0d", code, half), 32'(pulses), 32'(FRAMES));
        chk("R8 no pending pairs", 32'(exp_l.size()), 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge bclk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int code = 0; code < 8; code++) begin
            for (int hs = 0; hs < 2; hs++) begin
                run_config(code, hs);
            end
        end

        // zero-run detector, frame clock held so no pairs form
        apply_reset(3'b000);
        drive_bit(1'b1, 1'b1);
        for (int i = 0; i < ZLEN - 1; i++) drive_bit(1'b1, 1'b0);
        chk("R9 flag low one sample short", {31'd0, zero_flag}, 32'd0);
        drive_bit(1'b1, 1'b0);
        chk("R9 flag high at run length", {31'd0, zero_flag}, 32'd1);
        drive_bit(1'b1, 1'b1);
        chk("R10 one bit drops flag", {31'd0, zero_flag}, 32'd0);
        for (int i = 0; i < 1000; i++) drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b1);
        for (int i = 0; i < ZLEN - 1; i++) drive_bit(1'b1, 1'b0);
        chk("R10 count restarted after one bit", {31'd0, zero_flag}, 32'd0);
        drive_bit(1'b1, 1'b0);
        chk("R9 flag high after restarted run", {31'd0, zero_flag}, 32'd1);
        chk("R8 no strobe in zero test", 32'(exp_l.size()), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule